// File: doc/BRIEF.md
# Four-Stage In-Order Integer Pipeline

This block is a compact in-order integer core for a 32-bit RISC instruction subset. Instructions move through four stages: fetch, decode with register read, execute, and writeback. It executes register-register add and subtract (with and without the unsigned variants), add-immediate, word load and store, branch-if-equal, and jump-and-link. Instruction memory and data memory are small internal synchronous arrays. A write port at the edge fills the instruction array while the core is held in reset.

Control flow is resolved in execute. The core keeps fetching the fall-through path, holds decode while a branch or jump is in execute, and refetches from the target when the transfer is taken. Data dependences are covered by two bypasses: writeback into register read, and writeback into the ALU inputs. The only data stall is a single cycle for an instruction that consumes a load result directly. Every instruction that leaves writeback is reported on a registered retire strobe, with its address, whether it wrote a register, the register index and the value. This lets an instruction-by-instruction reference model follow the core.

Top module: `pipe4_core`

## Requirements
- R1: Primary opcode is instr[31:26]. Opcode 0 with function field instr[5:0] equal to 0x20 or 0x21 writes rs+rt into rd (instr[15:11]); 0x22 or 0x23 writes rs-rt. No overflow trap exists. Other function codes do nothing.
- R2: Opcodes 8 and 9 write rs plus the sign-extended instr[15:0] into rt (instr[20:16]).
- R3: Opcode 0x23 loads the data word at rs + sign-extended offset into rt. Opcode 0x2B stores rt at that address. The word index is address bits [DMEM_AW+1:2].
- R4: Opcode 4 compares rs with rt. When they differ, the next instruction retires two cycles after the branch, instead of one.
- R5: A taken branch goes to branch address + 4 + offset×4. A jump goes to {(address+4)[31:28], instr[25:0], 2'b00}. Either way, the next retire comes three cycles after the transfer, and the instructions fetched on the wrong path never retire.
- R6: Opcode 3 writes its own address + 4 into register 31.
- R7: An instruction that reads a result produced one or two instructions earlier by a non-load gets the new value and retires one cycle after its predecessor.
- R8: An instruction that reads the register loaded by the instruction directly ahead of it retires two cycles after that load, with the loaded value.
- R9: Register 0 reads as zero. A write aimed at it is dropped, and that instruction retires with ret_we low.
- R10: ret_valid is low during reset. Instruction 0 retires four clock edges after reset is released. At most one instruction retires per cycle.
- R11: Words written through the load port while reset is high are the program. Retirement follows the program's own sequence of addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Instruction array write enable |
| load_addr | input | IMEM_AW | Instruction word index to write |
| load_data | input | 32 | Instruction word to write |
| ret_valid | output | 1 | One instruction retired this cycle |
| ret_we | output | 1 | Retired instruction wrote a register |
| ret_rd | output | 5 | Register written |
| ret_data | output | 32 | Value written |
| ret_pc | output | 32 | Address of the retired instruction |

## Verification
Each retire is due at a cycle that can be predicted from the instruction before it. After an ordinary instruction the gap is one cycle. It is two after a not-taken branch, two after a load whose result is consumed at once, and three after any taken transfer. The first retire lands on the fourth edge after reset is released. The reference model steps one instruction ahead and adds that gap to the previous due cycle. On every falling edge it checks either a full retire record at the due cycle or a silent strobe on every other cycle. A retire that comes early or late, or an extra retire, is caught on the exact cycle where it happens.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  localparam int XLEN  = 32;
  localparam int RBITS = 5;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;

  typedef enum logic [2:0] {K_NOP, K_ALU, K_LOAD, K_STORE, K_BEQ, K_JAL} kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              sub;
    logic              use_rs;
    logic              use_rt;
    logic              imm_b;
    logic              we;
    logic [RBITS-1:0]  rd;
    logic [RBITS-1:0]  rs;
    logic [RBITS-1:0]  rt;
    logic [XLEN-1:0]   imm;
    logic [25:0]       jidx;
  } dec_t;
endpackage

// File: rtl/pipe4_ram.sv
module pipe4_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pipe4_decode.sv
module pipe4_decode
  import pipe4_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [5:0] op, fn;

  assign op = instr[31:26];
  assign fn = instr[5:0];

  always_comb begin
    dec        = '0;
    dec.kind   = K_NOP;
    dec.rs     = instr[25:21];
    dec.rt     = instr[20:16];
    dec.imm    = {{(XLEN-16){instr[15]}}, instr[15:0]};
    dec.jidx   = instr[25:0];
    unique case (op)
      OP_REG: begin
        if (fn == FN_ADD || fn == FN_ADDU || fn == FN_SUB || fn == FN_SUBU) begin
          dec.kind   = K_ALU;
          dec.use_rs = 1'b1;
          dec.use_rt = 1'b1;
          dec.sub    = fn[1];
          dec.we     = 1'b1;
          dec.rd     = instr[15:11];
        end
      end
      OP_ADDI, OP_ADDIU: begin
        dec.kind   = K_ALU;
        dec.use_rs = 1'b1;
        dec.imm_b  = 1'b1;
        dec.we     = 1'b1;
        dec.rd     = instr[20:16];
      end
      OP_LW: begin
        dec.kind   = K_LOAD;
        dec.use_rs = 1'b1;
        dec.we     = 1'b1;
        dec.rd     = instr[20:16];
      end
      OP_SW: begin
        dec.kind   = K_STORE;
        dec.use_rs = 1'b1;
        dec.use_rt = 1'b1;
      end
      OP_BEQ: begin
        dec.kind   = K_BEQ;
        dec.use_rs = 1'b1;
        dec.use_rt = 1'b1;
      end
      OP_JAL: begin
        dec.kind = K_JAL;
        dec.we   = 1'b1;
        dec.rd   = 5'd31;
      end
      default: ;
    endcase
    if (dec.rd == '0) dec.we = 1'b0;
  end
endmodule

// File: rtl/pipe4_regfile.sv
module pipe4_regfile
  import pipe4_pkg::*;
#(
  parameter int NRD = 2
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [RBITS-1:0]           waddr,
  input  logic [XLEN-1:0]            wdata,
  input  logic [NRD-1:0][RBITS-1:0]  raddr,
  output logic [NRD-1:0][XLEN-1:0]   rdata
);
  localparam int NREG = 1 << RBITS;

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
  import pipe4_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_we,
  input  logic [IMEM_AW-1:0] load_addr,
  input  logic [31:0]        load_data,
  output logic               ret_valid,
  output logic               ret_we,
  output logic [4:0]         ret_rd,
  output logic [31:0]        ret_data,
  output logic [31:0]        ret_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // fetch state and IF/ID
  logic [XLEN-1:0] fpc, if_pc, if_instr;
  logic            if_valid;
  // ID/EX
  dec_t            id_d, ex_dec;
  logic            ex_valid;
  logic [XLEN-1:0] ex_pc, ex_a, ex_b;
  // EX/WB
  logic            wb_valid, wb_we, wb_load;
  logic [RBITS-1:0] wb_rd;
  logic [XLEN-1:0] wb_pc, wb_res, dm_q;
  // datapath nets
  logic [1:0][RBITS-1:0] rf_addr;
  logic [1:0][XLEN-1:0]  rf_q;
  logic [XLEN-1:0] id_a, id_b, wb_value, op_a, op_b, alu_b, alu_y;
  logic [XLEN-1:0] mem_addr, ex_pc4, target;
  logic            wb_wr, ex_ctl, taken, load_stall, hold, fetch_re;
  logic            dm_we, dm_re;

  // ---------------- fetch ----------------
  assign fetch_re = !hold;

  pipe4_ram #(.AW(IMEM_AW), .DW(XLEN)) u_imem (
    .clk   (clk),
    .we    (load_we),
    .waddr (load_addr),
    .wdata (load_data),
    .re    (fetch_re),
    .raddr (fpc[IMEM_AW+1:2]),
    .rdata (if_instr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fpc      <= '0;
      if_valid <= 1'b0;
      if_pc    <= '0;
    end else if (taken) begin
      fpc      <= target;
      if_valid <= 1'b0;
    end else if (!hold) begin
      fpc      <= fpc + STEP;
      if_valid <= 1'b1;
      if_pc    <= fpc;
    end
  end

  // ---------------- decode / register read ----------------
  pipe4_decode u_dec (
    .instr (if_instr),
    .dec   (id_d)
  );

  assign rf_addr[0] = id_d.rs;
  assign rf_addr[1] = id_d.rt;

  pipe4_regfile #(.NRD(2)) u_rf (
    .clk   (clk),
    .we    (wb_wr),
    .waddr (wb_rd),
    .wdata (wb_value),
    .raddr (rf_addr),
    .rdata (rf_q)
  );

  assign wb_wr    = wb_valid && wb_we;
  assign wb_value = wb_load ? dm_q : wb_res;

  // writeback-to-read bypass: the register file is written at the end of this cycle
  assign id_a = (wb_wr && wb_rd == id_d.rs) ? wb_value : rf_q[0];
  assign id_b = (wb_wr && wb_rd == id_d.rt) ? wb_value : rf_q[1];

  assign ex_ctl     = ex_valid && (ex_dec.kind == K_BEQ || ex_dec.kind == K_JAL);
  assign load_stall = ex_valid && ex_dec.kind == K_LOAD && ex_dec.we && if_valid &&
                      ((id_d.use_rs && id_d.rs == ex_dec.rd) ||
                       (id_d.use_rt && id_d.rt == ex_dec.rd));
  assign hold       = ex_ctl || load_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_dec   <= '0;
      ex_pc    <= '0;
      ex_a     <= '0;
      ex_b     <= '0;
    end else if (hold) begin
      ex_valid <= 1'b0;
    end else begin
      ex_valid <= if_valid;
      ex_dec   <= id_d;
      ex_pc    <= if_pc;
      ex_a     <= id_a;
      ex_b     <= id_b;
    end
  end

  // ---------------- execute ----------------
  // pipeline-register bypass straight into the ALU inputs
  assign op_a = (wb_wr && wb_rd == ex_dec.rs) ? wb_value : ex_a;
  assign op_b = (wb_wr && wb_rd == ex_dec.rt) ? wb_value : ex_b;

  assign alu_b    = ex_dec.imm_b ? ex_dec.imm : op_b;
  assign alu_y    = ex_dec.sub ? (op_a - alu_b) : (op_a + alu_b);
  assign mem_addr = op_a + ex_dec.imm;
  assign ex_pc4   = ex_pc + STEP;
  assign target   = (ex_dec.kind == K_JAL) ? {ex_pc4[XLEN-1:XLEN-4], ex_dec.jidx, 2'b00}
                                           : ex_pc4 + {ex_dec.imm[XLEN-3:0], 2'b00};
  assign taken    = ex_valid && (ex_dec.kind == K_JAL ||
                                 (ex_dec.kind == K_BEQ && op_a == op_b));

  assign dm_we = ex_valid && ex_dec.kind == K_STORE;
  assign dm_re = ex_valid && ex_dec.kind == K_LOAD;

  pipe4_ram #(.AW(DMEM_AW), .DW(XLEN)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (mem_addr[DMEM_AW+1:2]),
    .wdata (op_b),
    .re    (dm_re),
    .raddr (mem_addr[DMEM_AW+1:2]),
    .rdata (dm_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_we    <= 1'b0;
      wb_load  <= 1'b0;
      wb_rd    <= '0;
      wb_pc    <= '0;
      wb_res   <= '0;
    end else begin
      wb_valid <= ex_valid;
      wb_we    <= ex_valid && ex_dec.we;
      wb_load  <= ex_dec.kind == K_LOAD;
      wb_rd    <= ex_dec.rd;
      wb_pc    <= ex_pc;
      wb_res   <= (ex_dec.kind == K_JAL) ? ex_pc4 : alu_y;
    end
  end

  // ---------------- writeback / retire ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 1'b0;
      ret_we    <= 1'b0;
      ret_rd    <= '0;
      ret_data  <= '0;
      ret_pc    <= '0;
    end else begin
      ret_valid <= wb_valid;
      ret_we    <= wb_wr;
      ret_rd    <= wb_rd;
      ret_data  <= wb_value;
      ret_pc    <= wb_pc;
    end
  end
endmodule

// File: rtl/pipe4_core_chk.sv
module pipe4_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        ret_valid,
  input logic        ret_we,
  input logic [4:0]  ret_rd,
  input logic [31:0] ret_pc,
  input logic        taken,
  input logic        if_valid,
  input logic        load_stall,
  input logic [31:0] fpc,
  input logic        ex_ctl,
  input logic        ex_valid
);
  a_r9_zero_never_written: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> !(ret_we && ret_rd == 5'd0));

  a_r11_retire_word_aligned: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> ret_pc[1:0] == 2'b00);

  a_r5_flush_after_redirect: assert property (@(posedge clk) disable iff (rst)
    taken |=> !if_valid);

  a_r8_fetch_frozen_on_load_use: assert property (@(posedge clk) disable iff (rst)
    load_stall |=> $stable(fpc));

  a_r4_bubble_behind_transfer: assert property (@(posedge clk) disable iff (rst)
    ex_ctl |=> !ex_valid);
endmodule

bind pipe4_core pipe4_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ret_valid  (ret_valid),
  .ret_we     (ret_we),
  .ret_rd     (ret_rd),
  .ret_pc     (ret_pc),
  .taken      (taken),
  .if_valid   (if_valid),
  .load_stall (load_stall),
  .fpc        (fpc),
  .ex_ctl     (ex_ctl),
  .ex_valid   (ex_valid)
);

// File: tb/pipe4_core_bench.sv
module pipe4_core_bench;
  localparam int IAW = 6;
  localparam int NWORDS = 1 << IAW;
  localparam int NRETIRE = 40;

  logic           clk = 1'b0;
  logic           rst;
  logic           load_we;
  logic [IAW-1:0] load_addr;
  logic [31:0]    load_data;
  logic           ret_valid, ret_we;
  logic [4:0]     ret_rd;
  logic [31:0]    ret_data, ret_pc;

  always #2 clk = ~clk;

  pipe4_core #(.IMEM_AW(IAW), .DMEM_AW(6)) u_pipe4_core (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
    .ret_valid(ret_valid), .ret_we(ret_we), .ret_rd(ret_rd), .ret_data(ret_data), .ret_pc(ret_pc)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int n_ret = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // ---------------- program encoders ----------------
  function automatic logic [31:0] er(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] ei(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] ej(input int idx);
    return {6'h03, 26'(idx)};
  endfunction

  logic [31:0] prog [NWORDS];

  // ---------------- reference model ----------------
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;
  int          e_cyc;
  logic [31:0] e_pc, e_data;
  logic        e_we;
  logic [4:0]  e_rd;
  string       e_tag, g_tag;
  int          prev_kind;
  logic [4:0]  prev_ld;

  task automatic iss_step();
    logic [31:0] ins, a, b, imm, addr, nxt, p4;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    bit          urs, urt;
    int          kind, g;
    logic [4:0]  ld;
    ins  = prog[m_pc[IAW+1:2]];
    op   = ins[31:26]; fn = ins[5:0];
    rs   = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    imm  = {{16{ins[15]}}, ins[15:0]};
    a    = (rs == 0) ? 32'd0 : m_reg[rs];
    b    = (rt == 0) ? 32'd0 : m_reg[rt];
    p4   = m_pc + 32'd4;
    nxt  = p4;
    urs  = 0; urt = 0; kind = 0; ld = 0;
    e_pc = m_pc; e_we = 0; e_rd = 0; e_data = 0; e_tag = "R11";
    case (op)
      6'h00: if (fn >= 6'h20 && fn <= 6'h23) begin
               urs = 1; urt = 1; e_tag = "R1";
               e_rd = rd; e_data = fn[1] ? a - b : a + b;
             end
      6'h08, 6'h09: begin urs = 1; e_tag = "R2"; e_rd = rt; e_data = a + imm; end
      6'h23: begin
               urs = 1; e_tag = "R3"; addr = a + imm;
               e_rd = rt; e_data = m_mem[addr[7:2]]; kind = 3; ld = rt;
             end
      6'h2B: begin urs = 1; urt = 1; e_tag = "R3"; addr = a + imm; m_mem[addr[7:2]] = b; end
      6'h04: begin
               urs = 1; urt = 1; e_tag = "R4";
               if (a == b) begin nxt = p4 + (imm << 2); kind = 2; end else kind = 1;
             end
      6'h03: begin
               e_tag = "R6"; e_rd = 5'd31; e_data = p4; kind = 2;
               nxt = {p4[31:28], ins[25:0], 2'b00};
             end
      default: ;
    endcase
    if (e_rd != 0) begin
      m_reg[e_rd] = e_data; e_we = 1;
    end else if (e_tag == "R1" || e_tag == "R2" || (op == 6'h23)) begin
      e_tag = "R9"; e_data = 0;
    end
    g = 1; g_tag = "R7";
    if (prev_kind == 1) begin g = 2; g_tag = "R4"; end
    if (prev_kind == 2) begin g = 3; g_tag = "R5"; end
    if (prev_kind == 3 && prev_ld != 0 && ((urs && rs == prev_ld) || (urt && rt == prev_ld))) begin
      g = 2; g_tag = "R8";
    end
    e_cyc += g;
    prev_kind = kind; prev_ld = ld;
    m_pc = nxt;
  endtask

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst) begin
      chk(ret_valid == 1'b0, "R10 quiet in reset", {31'd0, ret_valid}, 32'd0);
    end else if (!done) begin
      if (cyc == e_cyc) begin
        chk(ret_valid == 1'b1, {g_tag, " retire timing"}, {31'd0, ret_valid}, 32'd1);
        chk(ret_pc == e_pc, "R11 retire order", ret_pc, e_pc);
        chk(ret_we == e_we, {e_tag, " write flag"}, {31'd0, ret_we}, {31'd0, e_we});
        if (e_we) begin
          chk(ret_rd == e_rd, {e_tag, " dest reg"}, {27'd0, ret_rd}, {27'd0, e_rd});
          chk(ret_data == e_data, {e_tag, " value"}, ret_data, e_data);
        end
        n_ret++;
        if (n_ret == NRETIRE) done = 1'b1;
        else iss_step();
      end else begin
        chk(ret_valid == 1'b0, "R10 no retire off schedule", {31'd0, ret_valid}, 32'd0);
      end
    end
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) prog[i] = 32'd0;
    prog[0]  = ei(6'h08, 0, 1, 5);
    prog[1]  = ei(6'h08, 0, 2, -3);
    prog[2]  = er(6'h20, 1, 2, 3);
    prog[3]  = er(6'h22, 3, 1, 4);
    prog[4]  = er(6'h21, 4, 4, 5);
    prog[5]  = er(6'h23, 0, 5, 6);
    prog[6]  = ei(6'h09, 6, 7, 100);
    prog[7]  = ei(6'h2B, 0, 7, 8);
    prog[8]  = ei(6'h23, 0, 8, 8);
    prog[9]  = er(6'h20, 8, 1, 9);
    prog[10] = ei(6'h2B, 1, 9, -1);
    prog[11] = ei(6'h23, 0, 10, 4);
    prog[12] = ei(6'h08, 0, 11, 1);
    prog[13] = er(6'h20, 10, 11, 12);
    prog[14] = ei(6'h04, 1, 2, 5);
    prog[15] = ei(6'h04, 3, 3, 2);
    prog[16] = ei(6'h08, 0, 13, 99);
    prog[17] = ei(6'h08, 0, 13, 98);
    prog[18] = ei(6'h08, 0, 0, 7);
    prog[19] = er(6'h20, 0, 0, 14);
    prog[20] = ej(24);
    prog[21] = ei(6'h08, 0, 15, 1);
    prog[24] = er(6'h20, 31, 0, 16);
    prog[25] = ei(6'h23, 0, 17, 4);
    prog[26] = ei(6'h04, 17, 9, 1);
    prog[27] = ei(6'h08, 0, 18, 55);
    prog[28] = ei(6'h08, 17, 18, 1);
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    for (int i = 0; i < 64; i++) m_mem[i] = 32'd0;
    m_pc = 32'd0; prev_kind = 0; prev_ld = 0; e_cyc = 3;
    iss_step();

    rst = 1'b1; load_we = 1'b0; load_addr = '0; load_data = '0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NWORDS; i++) begin
      load_we = 1'b1; load_addr = IAW'(i); load_data = prog[i];
      @(negedge clk);
    end
    load_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    while (!done && cyc < 3000) @(negedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R10 watchdog: actual=%0d retires expected=%0d", n_ret, NRETIRE);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule